// File: doc/BRIEF.md
# Mode-Aware Data Cache Controller

This block is a direct-mapped data cache that sits between a CPU load/store port and one external memory bus. Each CPU access carries a two-bit page attribute that picks the caching policy for that access alone: copy-back, write-through or cache-inhibited. The controller keeps a tag, a valid bit and a modified bit for every line. It detects hits and misses, fills lines from memory and writes modified lines back. It also applies the invalidation rules of each policy. All of its memory traffic is serialised onto the single bus.

The CPU holds `cpu_req` and the access fields stable until `cpu_ready` is high for one cycle. A cached hit completes in the cycle it is presented. Anything that needs the bus holds `cpu_ready` low until the whole bus sequence is over. The bus side raises `bus_req` and waits for `bus_ack` on every beat. A line transfer (`bus_burst` high) takes four beats, and the address names each word.

Top module: `mdc_top`

## Requirements
- R1: After reset every line is invalid and the bus is idle: `cpu_ready` and `bus_req` are low, and the first cached load to any address fetches a line.
- R2: Attribute 0 is copy-back. A copy-back load hit returns cached data with no bus traffic. A copy-back store hit writes only the cache and marks the line modified.
- R3: On a copy-back or write-through miss, a modified victim line is written back as one 4-beat line write before the 4-beat line read of the new line. A clean victim is not written back. A copy-back store miss allocates the line and merges the store into it.
- R4: Address bits [3:2] select the word, [7:4] the line and [31:8] form the tag. Every line transfer starts at word 0 and steps up by one word per acknowledged beat.
- R5: Attribute 1 is write-through. A write-through store always makes exactly one single-word bus write carrying the CPU address, data and byte enables. On a hit, the cached word is updated as well.
- R6: A write-through store miss does not allocate a line, so a later cached load of that address still fetches a line.
- R7: Writes made in write-through mode never mark a line modified, so a line changed only that way is evicted without a write-back.
- R8: Write-through loads use the cache: a hit makes no bus access and a miss fills a line.
- R9: Attribute 2 or 3 is cache-inhibited. Such a load is one single-word bus read and such a store is one single-word bus write, and neither ever fills a line.
- R10: A cache-inhibited access that hits a modified line first writes that line back, then invalidates it, then performs its word access. A hit on a clean line is invalidated without a write-back.
- R11: `cpu_ready` is never high while `bus_req` is high. Load data is valid on `cpu_rdata` in the cycle `cpu_ready` is high.
- R12: Byte-enable bit k selects data bits 8k+7 to 8k for every store, whether to the cache or to the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, held until ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_be | input | 4 | Store byte enables |
| cpu_mode | input | 2 | Page attribute: 0 copy-back, 1 write-through, 2/3 inhibited |
| cpu_ready | output | 1 | Access complete this cycle |
| cpu_rdata | output | 32 | Load data, valid with ready |
| bus_req | output | 1 | Bus beat requested |
| bus_we | output | 1 | Bus beat is a write |
| bus_burst | output | 1 | Beat belongs to a 4-word line transfer |
| bus_addr | output | 32 | Bus byte address |
| bus_wdata | output | 32 | Bus write data |
| bus_be | output | 4 | Bus byte enables |
| bus_ack | input | 1 | Memory completes the current beat |
| bus_rdata | input | 32 | Memory read data, valid with ack |

## Verification
A wrong tag, valid or modified bit does not show at once. It shows on the next access that maps to the same line, as a missing or extra 4-beat write-back or fill, or as stale load data. A lost modified bit shows even later, as memory contents that differ from the expected image after eviction. The bench therefore compares the exact count of line reads, line writes and word transfers, and the load data, on every access. It also compares the whole memory image at the end.

// File: rtl/mdc_pkg.sv
package mdc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WB,
    ST_FILL,
    ST_WWR,
    ST_WRD,
    ST_RESP
  } mdc_state_e;

  localparam logic [1:0] ATTR_CB = 2'd0;
  localparam logic [1:0] ATTR_WT = 2'd1;
endpackage

// File: rtl/mdc_tag_store.sv
module mdc_tag_store #(
  parameter int LINES = 16,
  parameter int TAG_W = 24,
  parameter int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic [TAG_W-1:0] tag_in,
  input  logic             alloc,
  input  logic             inval,
  input  logic             set_dty,
  input  logic             clr_dty,
  output logic             hit,
  output logic             line_vld,
  output logic             line_dty,
  output logic [TAG_W-1:0] line_tag
);
  logic [LINES-1:0] valid_q, valid_d;
  logic [LINES-1:0] dirty_q, dirty_d;
  logic [TAG_W-1:0] tag_q [LINES];

  always_comb begin
    valid_d = valid_q;
    dirty_d = dirty_q;
    if (alloc) begin
      valid_d[idx] = 1'b1;
      dirty_d[idx] = 1'b0;
    end
    if (inval) begin
      valid_d[idx] = 1'b0;
      dirty_d[idx] = 1'b0;
    end
    if (set_dty) dirty_d[idx] = 1'b1;
    if (clr_dty) dirty_d[idx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) tag_q[idx] <= tag_in;
  end

  assign line_vld = valid_q[idx];
  assign line_dty = dirty_q[idx];
  assign line_tag = tag_q[idx];
  assign hit      = line_vld && (tag_q[idx] == tag_in);
endmodule

// File: rtl/mdc_data_store.sv
module mdc_data_store #(
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int IDX_W  = $clog2(LINES),
  parameter int OFF_W  = $clog2(WORDS),
  parameter int BE_W   = DATA_W / 8
) (
  input  logic                    clk,
  input  logic [IDX_W-1:0]        idx,
  input  logic                    we,
  input  logic [OFF_W-1:0]        wsel,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [BE_W-1:0]         be,
  output logic [WORDS*DATA_W-1:0] line_data
);
  logic [WORDS*DATA_W-1:0] mem_q [LINES];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < BE_W; b++) begin
        if (be[b]) mem_q[idx][int'(wsel)*DATA_W + b*8 +: 8] <= wdata[b*8 +: 8];
      end
    end
  end

  assign line_data = mem_q[idx];
endmodule

// File: rtl/mdc_ctrl.sv
module mdc_ctrl
  import mdc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int IDX_W  = 4,
  parameter int OFF_W  = $clog2(WORDS),
  parameter int BE_W   = DATA_W / 8,
  parameter int BOFF_W = $clog2(BE_W),
  parameter int TAG_W  = ADDR_W - IDX_W - OFF_W - BOFF_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_req,
  input  logic                    cpu_we,
  input  logic [1:0]              cpu_mode,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  input  logic [BE_W-1:0]         cpu_be,
  input  logic [IDX_W-1:0]        cpu_idx,
  input  logic [TAG_W-1:0]        cpu_tag,
  input  logic [OFF_W-1:0]        cpu_word,
  input  logic                    hit,
  input  logic                    line_vld,
  input  logic                    line_dty,
  input  logic [TAG_W-1:0]        line_tag,
  input  logic [WORDS*DATA_W-1:0] line_data,
  input  logic                    bus_ack,
  input  logic [DATA_W-1:0]       bus_rdata,
  output logic                    cpu_ready,
  output logic [DATA_W-1:0]       cpu_rdata,
  output logic                    bus_req,
  output logic                    bus_we,
  output logic                    bus_burst,
  output logic [ADDR_W-1:0]       bus_addr,
  output logic [DATA_W-1:0]       bus_wdata,
  output logic [BE_W-1:0]         bus_be,
  output logic                    alloc,
  output logic                    inval,
  output logic                    set_dty,
  output logic                    clr_dty,
  output logic                    dwe,
  output logic [OFF_W-1:0]        dwsel,
  output logic [DATA_W-1:0]       dwdata,
  output logic [BE_W-1:0]         dbe
);
  localparam logic [OFF_W-1:0] LAST = OFF_W'(WORDS - 1);

  mdc_state_e        state_q, state_d;
  logic [OFF_W-1:0]  beat_q, beat_d;
  logic [DATA_W-1:0] rsp_q;
  logic              rsp_en;
  logic              inhibit, thru;

  assign inhibit = cpu_mode[1];
  assign thru    = (cpu_mode == ATTR_WT);

  always_comb begin
    state_d   = state_q;
    beat_d    = beat_q;
    rsp_en    = 1'b0;
    cpu_ready = 1'b0;
    bus_req   = 1'b0;
    bus_we    = 1'b0;
    bus_burst = 1'b0;
    bus_addr  = cpu_addr;
    bus_wdata = cpu_wdata;
    bus_be    = cpu_be;
    alloc     = 1'b0;
    inval     = 1'b0;
    set_dty   = 1'b0;
    clr_dty   = 1'b0;
    dwe       = 1'b0;
    dwsel     = cpu_word;
    dwdata    = cpu_wdata;
    dbe       = cpu_be;
    case (state_q)
      ST_IDLE: begin
        if (cpu_req) begin
          beat_d = '0;
          if (inhibit) begin
            if (hit && line_dty) begin
              state_d = ST_WB;
            end else begin
              inval   = hit;
              state_d = cpu_we ? ST_WWR : ST_WRD;
            end
          end else if (thru && cpu_we) begin
            state_d = ST_WWR;
          end else if (hit) begin
            cpu_ready = 1'b1;
            if (cpu_we) begin
              dwe     = 1'b1;
              set_dty = 1'b1;
            end
          end else if (line_vld && line_dty) begin
            state_d = ST_WB;
          end else begin
            state_d = ST_FILL;
          end
        end
      end
      ST_WB: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_burst = 1'b1;
        bus_addr  = {line_tag, cpu_idx, beat_q, {BOFF_W{1'b0}}};
        bus_wdata = line_data[int'(beat_q)*DATA_W +: DATA_W];
        bus_be    = '1;
        if (bus_ack) begin
          beat_d = beat_q + 1'b1;
          if (beat_q == LAST) begin
            clr_dty = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_FILL: begin
        bus_req   = 1'b1;
        bus_burst = 1'b1;
        bus_addr  = {cpu_tag, cpu_idx, beat_q, {BOFF_W{1'b0}}};
        if (bus_ack) begin
          dwe    = 1'b1;
          dwsel  = beat_q;
          dwdata = bus_rdata;
          dbe    = '1;
          beat_d = beat_q + 1'b1;
          if (beat_q == LAST) begin
            alloc   = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_WWR: begin
        bus_req = 1'b1;
        bus_we  = 1'b1;
        if (bus_ack) begin
          dwe     = hit;
          state_d = ST_RESP;
        end
      end
      ST_WRD: begin
        bus_req = 1'b1;
        if (bus_ack) begin
          rsp_en  = 1'b1;
          state_d = ST_RESP;
        end
      end
      ST_RESP: begin
        cpu_ready = 1'b1;
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign cpu_rdata = (state_q == ST_RESP) ? rsp_q
                                          : line_data[int'(cpu_word)*DATA_W +: DATA_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rsp_en) rsp_q <= bus_rdata;
  end
endmodule

// File: rtl/mdc_top.sv
module mdc_top #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int WORDS  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_req,
  input  logic                 cpu_we,
  input  logic [ADDR_W-1:0]    cpu_addr,
  input  logic [DATA_W-1:0]    cpu_wdata,
  input  logic [DATA_W/8-1:0]  cpu_be,
  input  logic [1:0]           cpu_mode,
  output logic                 cpu_ready,
  output logic [DATA_W-1:0]    cpu_rdata,
  output logic                 bus_req,
  output logic                 bus_we,
  output logic                 bus_burst,
  output logic [ADDR_W-1:0]    bus_addr,
  output logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W/8-1:0]  bus_be,
  input  logic                 bus_ack,
  input  logic [DATA_W-1:0]    bus_rdata
);
  localparam int BE_W   = DATA_W / 8;
  localparam int BOFF_W = $clog2(BE_W);
  localparam int OFF_W  = $clog2(WORDS);
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W - BOFF_W;

  logic [IDX_W-1:0]        cpu_idx;
  logic [TAG_W-1:0]        cpu_tag;
  logic [OFF_W-1:0]        cpu_word;
  logic                    hit, line_vld, line_dty;
  logic [TAG_W-1:0]        line_tag;
  logic [WORDS*DATA_W-1:0] line_data;
  logic                    alloc, inval, set_dty, clr_dty;
  logic                    dwe;
  logic [OFF_W-1:0]        dwsel;
  logic [DATA_W-1:0]       dwdata;
  logic [BE_W-1:0]         dbe;

  assign cpu_word = cpu_addr[BOFF_W +: OFF_W];
  assign cpu_idx  = cpu_addr[BOFF_W+OFF_W +: IDX_W];
  assign cpu_tag  = cpu_addr[ADDR_W-1 -: TAG_W];

  mdc_tag_store #(.LINES(LINES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .idx(cpu_idx), .tag_in(cpu_tag),
    .alloc(alloc), .inval(inval), .set_dty(set_dty), .clr_dty(clr_dty),
    .hit(hit), .line_vld(line_vld), .line_dty(line_dty), .line_tag(line_tag)
  );

  mdc_data_store #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W),
                   .IDX_W(IDX_W), .OFF_W(OFF_W), .BE_W(BE_W)) u_data (
    .clk(clk), .idx(cpu_idx), .we(dwe), .wsel(dwsel), .wdata(dwdata),
    .be(dbe), .line_data(line_data)
  );

  mdc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .IDX_W(IDX_W),
             .OFF_W(OFF_W), .BE_W(BE_W), .BOFF_W(BOFF_W), .TAG_W(TAG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_mode(cpu_mode), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_be(cpu_be), .cpu_idx(cpu_idx), .cpu_tag(cpu_tag), .cpu_word(cpu_word),
    .hit(hit), .line_vld(line_vld), .line_dty(line_dty), .line_tag(line_tag),
    .line_data(line_data), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .bus_req(bus_req),
    .bus_we(bus_we), .bus_burst(bus_burst), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .alloc(alloc), .inval(inval),
    .set_dty(set_dty), .clr_dty(clr_dty), .dwe(dwe), .dwsel(dwsel),
    .dwdata(dwdata), .dbe(dbe)
  );
endmodule

// File: rtl/mdc_checker.sv
module mdc_checker #(
  parameter int WORDS = 4,
  parameter int OFF_W = $clog2(WORDS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_we,
  input logic [1:0]       cpu_mode,
  input logic             cpu_ready,
  input logic             bus_req,
  input logic             bus_we,
  input logic             bus_burst,
  input logic             bus_ack,
  input logic [OFF_W-1:0] bus_off
);
  localparam logic [OFF_W-1:0] LAST = OFF_W'(WORDS - 1);

  assert_ready_held_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !cpu_ready);

  assert_burst_from_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_req) && bus_burst) |-> (bus_off == '0));

  assert_burst_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_burst && bus_ack && (bus_off != LAST))
      |=> (bus_req && bus_burst && (bus_off == $past(bus_off) + 1'b1)));

  assert_inhibit_no_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_burst && !bus_we) |-> !cpu_mode[1]);

  assert_word_write_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && !bus_burst) |-> (cpu_we && (cpu_mode != 2'd0)));

  assert_wt_store_done_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cpu_we && (cpu_mode == 2'd1)) |-> $past(bus_req && bus_we && bus_ack));
endmodule

bind mdc_top mdc_checker #(.WORDS(WORDS), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_mode(cpu_mode),
  .cpu_ready(cpu_ready), .bus_req(bus_req), .bus_we(bus_we),
  .bus_burst(bus_burst), .bus_ack(bus_ack),
  .bus_off(bus_addr[BOFF_W +: OFF_W])
);

// File: tb/sim_mdc_top.sv
module sim_mdc_top;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        cpu_req, cpu_we;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic [3:0]  cpu_be;
  logic [1:0]  cpu_mode;
  logic        cpu_ready;
  logic        bus_req, bus_we, bus_burst, bus_ack;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [3:0]  bus_be;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  logic [31:0] mem     [256];
  logic [31:0] ref_mem [256];
  logic        ref_v   [16];
  logic        ref_d   [16];
  logic [1:0]  ref_t   [16];
  logic [31:0] ref_dat [16][4];

  int n_lr, n_lw, n_wr, n_ww;
  int beat_exp = 0;

  mdc_top u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
    .cpu_mode(cpu_mode), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_burst(bus_burst),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] be);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    return r;
  endfunction

  // Memory responder: one wait cycle between beats, acts at the falling edge.
  always @(negedge clk) begin
    cyc++;
    if (rst_n) chk(!(bus_req && cpu_ready), "R11", "ready during bus", {31'd0, cpu_ready}, 32'd0);
    if (bus_ack) begin
      bus_ack = 1'b0;
    end else if (rst_n && bus_req) begin
      bus_ack   = 1'b1;
      bus_rdata = mem[bus_addr[9:2]];
      if (bus_we) mem[bus_addr[9:2]] = merge(mem[bus_addr[9:2]], bus_wdata, bus_be);
      if (bus_burst) begin
        chk(int'(bus_addr[3:2]) == beat_exp, "R4", "burst word order", {30'd0, bus_addr[3:2]}, beat_exp);
        beat_exp = (beat_exp + 1) % 4;
        if (bus_addr[3:2] == 2'd3) begin
          if (bus_we) n_lw++; else n_lr++;
        end
      end else begin
        if (bus_we) n_ww++; else n_wr++;
      end
    end
  end

  task automatic model(input logic [31:0] a, input bit we, input logic [31:0] wd,
                       input logic [3:0] be, input logic [1:0] md,
                       output logic [31:0] rd, output logic [15:0] ops);
    logic [3:0] idx = a[7:4];
    logic [1:0] tg  = a[9:8];
    logic [1:0] w   = a[3:2];
    logic [7:0] mi  = a[9:2];
    bit hit = ref_v[idx] && (ref_t[idx] == tg);
    int lr = 0, lw = 0, wr = 0, ww = 0;
    rd = '0;
    if (md[1]) begin
      if (hit) begin
        if (ref_d[idx]) begin
          for (int k = 0; k < 4; k++) ref_mem[{ref_t[idx], idx, 2'(k)}] = ref_dat[idx][k];
          lw = 1;
        end
        ref_v[idx] = 1'b0;
        ref_d[idx] = 1'b0;
      end
      if (we) begin ref_mem[mi] = merge(ref_mem[mi], wd, be); ww = 1; end
      else begin rd = ref_mem[mi]; wr = 1; end
    end else if (md == 2'd1 && we) begin
      ref_mem[mi] = merge(ref_mem[mi], wd, be);
      ww = 1;
      if (hit) ref_dat[idx][w] = merge(ref_dat[idx][w], wd, be);
    end else begin
      if (!hit) begin
        if (ref_v[idx] && ref_d[idx]) begin
          for (int k = 0; k < 4; k++) ref_mem[{ref_t[idx], idx, 2'(k)}] = ref_dat[idx][k];
          lw = 1;
        end
        for (int k = 0; k < 4; k++) ref_dat[idx][k] = ref_mem[{tg, idx, 2'(k)}];
        lr = 1;
        ref_v[idx] = 1'b1;
        ref_t[idx] = tg;
        ref_d[idx] = 1'b0;
      end
      if (we) begin
        ref_dat[idx][w] = merge(ref_dat[idx][w], wd, be);
        ref_d[idx] = 1'b1;
      end else rd = ref_dat[idx][w];
    end
    ops = {4'(lr), 4'(lw), 4'(wr), 4'(ww)};
  endtask

  // ops nibbles: line reads, line writes, word reads, word writes
  task automatic acc(input string req, input logic [31:0] a, input bit we,
                     input logic [31:0] wd, input logic [3:0] be, input logic [1:0] md);
    logic [31:0] erd, ard;
    logic [15:0] eops, aops;
    int waitc = 0;
    model(a, we, wd, be, md, erd, eops);
    n_lr = 0; n_lw = 0; n_wr = 0; n_ww = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_be = be; cpu_mode = md;
    forever begin
      #1;
      if (cpu_ready) break;
      @(negedge clk);
      waitc++;
      if (waitc > 2000) break;
    end
    ard = cpu_rdata;
    chk(cpu_ready, req, "access completes", {31'd0, cpu_ready}, 32'd1);
    @(posedge clk);
    #1 cpu_req = 1'b0;
    aops = {4'(n_lr), 4'(n_lw), 4'(n_wr), 4'(n_ww)};
    chk(aops == eops, req, $sformatf("bus ops @%h", a), {16'd0, aops}, {16'd0, eops});
    if (!we) chk(ard == erd, req, $sformatf("load data @%h", a), ard, erd);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 32'hC0DE_0000 | i;
      ref_mem[i] = mem[i];
    end
    for (int i = 0; i < 16; i++) begin ref_v[i] = 1'b0; ref_d[i] = 1'b0; ref_t[i] = '0; end
    rst_n = 1'b0; bus_ack = 1'b0; bus_rdata = '0;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0; cpu_be = '0; cpu_mode = '0;
    repeat (3) @(negedge clk);
    chk(!cpu_ready && !bus_req, "R1", "idle in reset", {30'd0, cpu_ready, bus_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cpu_ready && !bus_req, "R1", "idle after reset", {30'd0, cpu_ready, bus_req}, 32'd0);

    acc("R1", 32'h014, 1'b0, 0, 4'h0, 2'd0);               // first load fills
    acc("R2", 32'h014, 1'b1, 32'hDEADBEEF, 4'hF, 2'd0);    // store hit, no bus
    acc("R2", 32'h014, 1'b0, 0, 4'h0, 2'd0);
    acc("R3", 32'h114, 1'b0, 0, 4'h0, 2'd0);               // dirty victim written back
    acc("R5", 32'h118, 1'b1, 32'h12345678, 4'hF, 2'd1);    // write-through hit
    acc("R8", 32'h118, 1'b0, 0, 4'h0, 2'd1);               // write-through load hit
    acc("R6", 32'h220, 1'b1, 32'hA5A5A5A5, 4'hF, 2'd1);    // write-through miss
    acc("R6", 32'h220, 1'b0, 0, 4'h0, 2'd0);               // still fills
    acc("R7", 32'h018, 1'b0, 0, 4'h0, 2'd0);               // clean eviction
    acc("R8", 32'h2A4, 1'b0, 0, 4'h0, 2'd1);               // write-through load miss
    acc("R3", 32'h034, 1'b1, 32'h0000BEEF, 4'b0011, 2'd0); // store miss allocates
    acc("R12", 32'h034, 1'b0, 0, 4'h0, 2'd0);
    acc("R10", 32'h034, 1'b0, 0, 4'h0, 2'd2);              // inhibited hit on modified
    acc("R10", 32'h034, 1'b0, 0, 4'h0, 2'd2);              // now invalid
    acc("R10", 32'h030, 1'b0, 0, 4'h0, 2'd0);
    acc("R10", 32'h030, 1'b1, 32'h00990000, 4'b0100, 2'd3); // inhibited hit on clean
    acc("R9", 32'h030, 1'b0, 0, 4'h0, 2'd0);
    acc("R9", 32'h3C0, 1'b1, 32'h77777777, 4'hF, 2'd2);
    acc("R9", 32'h3C0, 1'b0, 0, 4'h0, 2'd2);
    acc("R12", 32'h2A4, 1'b1, 32'hFF00FF00, 4'b1010, 2'd1);
    acc("R12", 32'h2A4, 1'b0, 0, 4'h0, 2'd1);

    for (int n = 0; n < 400; n++) begin
      logic [31:0] ra = ($urandom % 1024) & 32'h3FC;
      logic [3:0]  rb = 4'($urandom % 15) + 4'd1;
      acc("R11", ra, 1'($urandom % 2), $urandom, rb, 2'($urandom % 4));
    end

    // flush modified lines through inhibited loads, then compare memory
    for (int i = 0; i < 16; i++)
      if (ref_v[i]) acc("R10", {22'd0, ref_t[i], 4'(i), 4'd0}, 1'b0, 0, 4'h0, 2'd2);
    for (int i = 0; i < 256; i++)
      chk(mem[i] === ref_mem[i], "R3", $sformatf("memory word %0d", i), mem[i], ref_mem[i]);
    finish_run();
  end
endmodule